// File: doc/BRIEF.md
# Periodic Output Impedance Calibration Controller

This block maintains two binary impedance codes for an output driver: one for the pull-up half, which drives a 1, and one for the pull-down half, which drives a 0. A free-running interval counter starts an evaluation at a fixed period, so the codes follow supply-voltage and temperature drift. At each evaluation the block samples an increase flag and a decrease flag for each half, which an external comparator provides. It then works out a new code that is at most one step away from the code currently applied.

A new code does not reach the driver at once. Each half keeps the new value pending until that half is idle. The pull-down code can change only while the output is tristated or every data bit is 1. The pull-up code can change only while the output is tristated or every data bit is 0. This means the half that is currently shaping the line is never retuned in the middle of a drive. A later evaluation overwrites any pending value. Both code buses come straight from registers.

Top module: `zq_cal_ctrl`

## Requirements
- R1: While reset is high, both codes load mid-scale. Mid-scale is a 1 in the most significant bit and zeros elsewhere (4 for a 3-bit code). The interval counter also clears.
- R2: The increase and decrease flags are sampled only at the rising edge that ends the INTERVAL-th cycle after reset is released, and then once every INTERVAL edges. No code changes before the edge that follows the first evaluation.
- R3: At an evaluation, an increase flag alone gives the applied code plus one, and a decrease flag alone gives the applied code minus one. Both flags high, or both low, give no change and discard any value that is pending for that half.
- R4: The codes saturate. A step up from all-ones stays at all-ones, and a step down from zero stays at zero. A code never wraps around.
- R5: The pull-down code changes only at an edge where the output enable is low or every data bit is 1.
- R6: The pull-up code changes only at an edge where the output enable is low or every data bit is 0.
- R7: A value that cannot be applied stays pending. An evaluation always works from the applied code, never from the pending value. A newer evaluation replaces the pending value, so pending steps never add up.
- R8: A pending value is applied at the first edge after its evaluation edge at which the gate for its half is open. No value is applied at an evaluation edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pu_inc | input | 1 | Comparator asks for a higher pull-up code |
| pu_dec | input | 1 | Comparator asks for a lower pull-up code |
| pd_inc | input | 1 | Comparator asks for a higher pull-down code |
| pd_dec | input | 1 | Comparator asks for a lower pull-down code |
| dq_out | input | DQ_W | Data the driver currently puts on the line |
| dq_oe | input | 1 | Output enable; low means the output is tristated |
| pu_code | output | CODE_W | Applied pull-up impedance code |
| pd_code | output | CODE_W | Applied pull-down impedance code |

## Verification
The comparator flags take effect only at an evaluation edge, so the bench holds them steady for a whole interval. Each check is placed at a falling edge whose count from reset release the bench knows. A pending value can show on a code bus one edge after its evaluation edge at the earliest. Before that point a code must still show its old value, and the directed checks sample on both sides of that boundary. In a closed-gate case, the bench checks the code several cycles after the evaluation and then again one edge after it opens the gate. An arithmetic model in the bench follows the same edge counting and compares both buses at every falling edge. This covers a sweep of every flag pairing against output patterns that change every cycle.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef enum int unsigned {
    HALF_PU = 0,
    HALF_PD = 1
  } half_e;

  localparam int unsigned NUM_HALVES = 2;

  function automatic step_e decode_step(input logic inc, input logic dec);
    step_e s;
    unique case ({inc, dec})
      2'b10:   s = STEP_UP;
      2'b01:   s = STEP_DOWN;
      default: s = STEP_HOLD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/zq_interval_timer.sv
module zq_interval_timer #(
  parameter int unsigned INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/zq_drive_gate.sv
module zq_drive_gate #(
  parameter int unsigned DQ_W = 8
) (
  input  logic [DQ_W-1:0] dq_out,
  input  logic            dq_oe,
  output logic            pu_free,
  output logic            pd_free
);
  // A half is free when the line is tristated or when the opposite level
  // is being driven on every bit.
  assign pu_free = !dq_oe || (dq_out == '0);
  assign pd_free = !dq_oe || (dq_out == '1);

endmodule

// File: rtl/zq_code_track.sv
module zq_code_track
  import zq_cal_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              inc,
  input  logic              dec,
  input  logic              gate_open,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MAX = '1;
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] pend_q;
  logic              pend_vld_q;
  logic [CODE_W-1:0] stepped;
  step_e             step;

  assign step = decode_step(inc, dec);

  // One saturating step away from the code that is applied now.
  always_comb begin
    unique case (step)
      STEP_UP:   stepped = (code_q == MAX) ? code_q : code_q + ONE;
      STEP_DOWN: stepped = (code_q == '0)  ? code_q : code_q - ONE;
      default:   stepped = code_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= MID;
      pend_q     <= MID;
      pend_vld_q <= 1'b0;
    end else if (tick) begin
      pend_q     <= stepped;
      pend_vld_q <= (step != STEP_HOLD);
    end else if (pend_vld_q && gate_open) begin
      code_q     <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl
  import zq_cal_pkg::*;
#(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned DQ_W     = 8,
  parameter int unsigned INTERVAL = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pu_inc,
  input  logic              pu_dec,
  input  logic              pd_inc,
  input  logic              pd_dec,
  input  logic [DQ_W-1:0]   dq_out,
  input  logic              dq_oe,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code
);
  logic                    tick;
  logic                    pu_free;
  logic                    pd_free;
  logic [NUM_HALVES-1:0]   inc_v;
  logic [NUM_HALVES-1:0]   dec_v;
  logic [NUM_HALVES-1:0]   free_v;
  logic [CODE_W-1:0]       code_v [NUM_HALVES];

  zq_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  zq_drive_gate #(.DQ_W(DQ_W)) u_gate (
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .pu_free (pu_free),
    .pd_free (pd_free)
  );

  assign inc_v[HALF_PU]  = pu_inc;
  assign dec_v[HALF_PU]  = pu_dec;
  assign free_v[HALF_PU] = pu_free;
  assign inc_v[HALF_PD]  = pd_inc;
  assign dec_v[HALF_PD]  = pd_dec;
  assign free_v[HALF_PD] = pd_free;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    zq_code_track #(.CODE_W(CODE_W)) u_track (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .inc       (inc_v[g]),
      .dec       (dec_v[g]),
      .gate_open (free_v[g]),
      .code      (code_v[g])
    );
  end

  assign pu_code = code_v[HALF_PU];
  assign pd_code = code_v[HALF_PD];

endmodule

// File: rtl/zq_cal_chk.sv
module zq_cal_chk #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned DQ_W     = 8,
  parameter int unsigned INTERVAL = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic [DQ_W-1:0]   dq_out,
  input logic              dq_oe,
  input logic [CODE_W-1:0] pu_code,
  input logic [CODE_W-1:0] pd_code
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MAX = '1;
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
  localparam int unsigned SW = $clog2(INTERVAL + 1);
  localparam logic [SW-1:0] SLIM = SW'(INTERVAL);

  logic          rst_d;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) since_q <= '0;
    else if (since_q < SLIM) since_q <= since_q + SW'(1);
  end

  // R1: first edge after reset release still shows the reset codes
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      a_r1_reset_mid: assert (pu_code == MID && pd_code == MID);
    end
  end

  // R2: nothing moves before the first evaluation has been applied
  a_r2_no_early_change: assert property (@(posedge clk) disable iff (rst)
    (since_q < SLIM) |-> (pu_code == MID && pd_code == MID));

  // R3 and R4: single saturating step, no wrap
  a_r4_pu_single_step: assert property (@(posedge clk) disable iff (rst)
    (pu_code == $past(pu_code)) ||
    (pu_code == $past(pu_code) + ONE && $past(pu_code) != MAX) ||
    (pu_code == $past(pu_code) - ONE && $past(pu_code) != '0));

  a_r4_pd_single_step: assert property (@(posedge clk) disable iff (rst)
    (pd_code == $past(pd_code)) ||
    (pd_code == $past(pd_code) + ONE && $past(pd_code) != MAX) ||
    (pd_code == $past(pd_code) - ONE && $past(pd_code) != '0));

  a_r5_pd_gated: assert property (@(posedge clk) disable iff (rst)
    (pd_code != $past(pd_code)) |-> $past(!dq_oe || (dq_out == '1)));

  a_r6_pu_gated: assert property (@(posedge clk) disable iff (rst)
    (pu_code != $past(pu_code)) |-> $past(!dq_oe || (dq_out == '0)));

endmodule

bind zq_cal_ctrl zq_cal_chk #(
  .CODE_W   (CODE_W),
  .DQ_W     (DQ_W),
  .INTERVAL (INTERVAL)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe),
  .pu_code (pu_code),
  .pd_code (pd_code)
);

// File: tb/tb_zq_cal_ctrl.sv
module tb_zq_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W   = 3;
  localparam int DQ_W     = 2;
  localparam int INTERVAL = 8;
  localparam int MAXC     = (1 << CODE_W) - 1;
  localparam int MIDC     = 1 << (CODE_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pu_inc = 0, pu_dec = 0, pd_inc = 0, pd_dec = 0;
  logic [DQ_W-1:0] dq_out = '0;
  logic dq_oe = 1'b0;
  logic [CODE_W-1:0] pu_code, pd_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_cal_ctrl #(.CODE_W(CODE_W), .DQ_W(DQ_W), .INTERVAL(INTERVAL)) dut (
    .clk(clk), .rst(rst), .pu_inc(pu_inc), .pu_dec(pu_dec),
    .pd_inc(pd_inc), .pd_dec(pd_dec), .dq_out(dq_out), .dq_oe(dq_oe),
    .pu_code(pu_code), .pd_code(pd_code)
  );

  // Arithmetic model built from the requirements.
  int cyc = 0;
  int m_pu = MIDC, m_pd = MIDC, p_pu = 0, p_pd = 0;
  bit v_pu = 0, v_pd = 0;

  function automatic int step_of(int c, logic inc, logic dec);
    if (inc && !dec) return (c == MAXC) ? c : c + 1;
    if (dec && !inc) return (c == 0) ? c : c - 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; m_pu = MIDC; m_pd = MIDC; v_pu = 0; v_pd = 0;
    end else begin
      if (cyc % INTERVAL == INTERVAL - 1) begin
        p_pu = step_of(m_pu, pu_inc, pu_dec); v_pu = (pu_inc != pu_dec);
        p_pd = step_of(m_pd, pd_inc, pd_dec); v_pd = (pd_inc != pd_dec);
      end else begin
        if (v_pu && (!dq_oe || dq_out == '0)) begin m_pu = p_pu; v_pu = 0; end
        if (v_pd && (!dq_oe || dq_out == '1)) begin m_pd = p_pd; v_pd = 0; end
      end
      cyc = cyc + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Continuous model comparison (R8 timing, R3/R4 arithmetic under sweep).
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 pu_code model", int'(pu_code), m_pu);
      check("R8 pd_code model", int'(pd_code), m_pd);
    end
  end

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the falling edge right after an evaluation edge.
  task automatic sync_eval();
    do @(negedge clk); while (cyc % INTERVAL != 0);
  endtask

  task automatic set_flags(logic a, logic b, logic c, logic d);
    pu_inc = a; pu_dec = b; pd_inc = c; pd_dec = d;
  endtask

  initial begin
    adv(3);
    check("R1 pu_code in reset", int'(pu_code), MIDC);
    check("R1 pd_code in reset", int'(pd_code), MIDC);
    rst = 1'b0;

    // R2 / R8: first evaluation at edge INTERVAL, applied one edge later
    dq_oe = 0; set_flags(1, 0, 0, 0);
    adv(INTERVAL);
    check("R2 pu before apply", int'(pu_code), MIDC);
    adv(1);
    check("R8 pu applied next edge", int'(pu_code), MIDC + 1);

    // R4: saturation at both ends
    set_flags(1, 0, 0, 1);
    repeat (5) sync_eval();
    adv(1);
    check("R4 pu saturates high", int'(pu_code), MAXC);
    check("R4 pd saturates low", int'(pd_code), 0);
    sync_eval(); adv(1);
    check("R4 pu no wrap", int'(pu_code), MAXC);
    check("R4 pd no wrap", int'(pd_code), 0);

    // R5: driving zeros blocks the pull-down update, frees the pull-up
    dq_oe = 1; dq_out = 2'b00; set_flags(0, 1, 1, 0);
    sync_eval(); set_flags(0, 0, 0, 0);
    adv(2);
    check("R5 pd held while driving 0", int'(pd_code), 0);
    check("R6 pu applied while driving 0", int'(pu_code), MAXC - 1);
    dq_out = 2'b11; adv(1);
    check("R5 pd applied once driving 1", int'(pd_code), 1);

    // R6: driving ones blocks the pull-up update
    set_flags(1, 0, 0, 0);
    sync_eval(); set_flags(0, 0, 0, 0);
    adv(2);
    check("R6 pu held while driving 1", int'(pu_code), MAXC - 1);
    dq_out = 2'b00; adv(1);
    check("R6 pu applied once driving 0", int'(pu_code), MAXC);

    // R7: mixed data closes both gates; second evaluation replaces first
    dq_out = 2'b01;
    set_flags(1, 0, 1, 0); sync_eval();
    set_flags(0, 1, 1, 0); sync_eval();
    set_flags(0, 0, 0, 0); adv(2);
    check("R7 pu still held", int'(pu_code), MAXC);
    dq_oe = 0; adv(1);
    check("R7 pu replaced pending", int'(pu_code), MAXC - 1);
    check("R7 pd no stacking", int'(pd_code), 2);

    // R3: both flags high gives no change
    set_flags(1, 1, 1, 1); sync_eval(); adv(2);
    check("R3 pu both flags hold", int'(pu_code), MAXC - 1);
    check("R3 pd both flags hold", int'(pd_code), 2);

    // R3: a no-move evaluation discards a held value
    dq_oe = 1; dq_out = 2'b01;
    set_flags(1, 0, 0, 1); sync_eval();
    set_flags(0, 0, 0, 0); sync_eval();
    dq_oe = 0; adv(3);
    check("R3 pu pending cancelled", int'(pu_code), MAXC - 1);
    check("R3 pd pending cancelled", int'(pd_code), 2);

    // Sweep: every flag pairing against output patterns changing each cycle
    for (int k = 0; k < INTERVAL * 16 * 8; k++) begin
      int f;
      int g;
      f = (k / INTERVAL) % 16;
      g = (k * 5 + k / 3) % 8;
      set_flags(f[0], f[1], f[2], f[3]);
      dq_oe = g[2];
      dq_out = g[1:0];
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule